// File: doc/BRIEF.md
# Dual-Issue Pairing Controller

This block sits at the end of the decode stage of a two-wide in-order pipeline. Each cycle it looks at the two oldest decoded instructions, called the lead slot and the trail slot, and decides whether both may enter execute together, only the lead one, or neither. The pairing rules are these. The two may not share the single data-memory port. Branches and long multiplies never travel with a partner. The trail instruction may not read or overwrite a register that the lead instruction writes. When only the lead slot goes, the trail instruction is held and becomes the lead slot of the next cycle.

The block also keeps one register of state: whether the lead or trail instruction issued in the previous cycle was a load, and which register that load writes. A load is a memory access that writes a register. If the new lead instruction needs that value, the block inserts a single empty cycle. If only the trail instruction needs it, the trail instruction is held back. A flush input cancels all issue in the cycle it is asserted and also discards the remembered load. Register 0 is an ordinary register in every comparison.

Top module: `dip_issue_ctrl`

## Requirements
- R1: While both slots are invalid, issue0, issue1 and hold1 are 0 and consumed is 0. This is also the state just after reset, and no load is remembered after reset.
- R2: Both slots do not issue together when both have the memory flag set. In that case the lead slot issues alone.
- R3: When the lead slot writes register d and an enabled source field of the trail slot names d, only the lead slot issues.
- R4: When both slots write the same destination register, only the lead slot issues.
- R5: A branch flag on either slot limits the cycle to the lead slot alone.
- R6: A long-multiply flag on either slot limits the cycle to the lead slot alone.
- R7: consumed (2 bits) equals issue0 + issue1. hold1 is 1 exactly when the trail slot is valid and issue1 is 0. Independent valid pairs give issue0 = issue1 = 1 and consumed = 2.
- R8: After a cycle in which a load (memory flag and write enable both 1) issued with destination d, a lead slot with an enabled source naming d issues nothing for one cycle (issue0 = 0, consumed = 0). In the following cycle it issues.
- R9: When the lead slot is independent but an enabled source of the trail slot names the destination of a load issued in the previous cycle, only the lead slot issues.
- R10: flush forces issue0 and issue1 to 0 in the same cycle. It also clears the remembered load, so the next cycle sees no load-use stall.
- R11: A valid lead slot with an invalid trail slot issues alone with hold1 = 0. An invalid lead slot issues nothing, whatever the trail slot holds.
- R12: Register index 0 takes part in the dependence checks like any other register.
- R13: A source field whose enable bit is 0 never causes a split or a stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Cancel issue this cycle and forget the pending load |
| s0_valid | input | 1 | Lead slot holds an instruction |
| s0_wen | input | 1 | Lead slot writes a register |
| s0_dst | input | 4 | Lead slot destination index |
| s0_sa_en | input | 1 | Lead slot first source used |
| s0_sa | input | 4 | Lead slot first source index |
| s0_sb_en | input | 1 | Lead slot second source used |
| s0_sb | input | 4 | Lead slot second source index |
| s0_mem | input | 1 | Lead slot accesses data memory |
| s0_branch | input | 1 | Lead slot is a branch |
| s0_mull | input | 1 | Lead slot is a long multiply |
| s1_valid | input | 1 | Trail slot holds an instruction |
| s1_wen | input | 1 | Trail slot writes a register |
| s1_dst | input | 4 | Trail slot destination index |
| s1_sa_en | input | 1 | Trail slot first source used |
| s1_sa | input | 4 | Trail slot first source index |
| s1_sb_en | input | 1 | Trail slot second source used |
| s1_sb | input | 4 | Trail slot second source index |
| s1_mem | input | 1 | Trail slot accesses data memory |
| s1_branch | input | 1 | Trail slot is a branch |
| s1_mull | input | 1 | Trail slot is a long multiply |
| issue0 | output | 1 | Lead slot issues this cycle |
| issue1 | output | 1 | Trail slot issues this cycle |
| hold1 | output | 1 | Valid trail slot is held back |
| consumed | output | 2 | Number of instructions issued |

## Verification
Two functions can act in the same cycle: the remembered-load stall and a pairing split or flush. The bench provokes both together. In one test a load issues and is followed by a pair whose trail slot alone reads the loaded register. In another, a pending load meets a flush in the next cycle. The stall must take priority or combine with the pairing rule correctly, which is judged from issue0, issue1, hold1 and consumed in that cycle and in the cycle after it.

// File: rtl/dip_pkg.sv
package dip_pkg;
    localparam int NUM_REGS = 16;
    localparam int RW       = $clog2(NUM_REGS);
    localparam int CW       = 2;

    typedef struct packed {
        logic          pend;
        logic [RW-1:0] dst;
    } ld_track_t;
endpackage

// File: rtl/dip_reads.sv
module dip_reads
    import dip_pkg::*;
(
    input  logic          probe_valid,
    input  logic [RW-1:0] probe_reg,
    input  logic          sa_en,
    input  logic [RW-1:0] sa,
    input  logic          sb_en,
    input  logic [RW-1:0] sb,
    output logic          hit
);
    always_comb begin
        hit = probe_valid &&
              ((sa_en && (sa == probe_reg)) || (sb_en && (sb == probe_reg)));
    end
endmodule

// File: rtl/dip_pair_rules.sv
module dip_pair_rules
    import dip_pkg::*;
(
    input  logic          s1_valid,
    input  logic          s0_wen,
    input  logic [RW-1:0] s0_dst,
    input  logic          s1_wen,
    input  logic [RW-1:0] s1_dst,
    input  logic          s0_mem,
    input  logic          s1_mem,
    input  logic          s0_branch,
    input  logic          s1_branch,
    input  logic          s0_mull,
    input  logic          s1_mull,
    input  logic          raw_hit,
    input  logic          ld_hit1,
    output logic          pair_ok
);
    logic port_clash;
    logic solo_kind;
    logic waw_hit;

    always_comb begin
        port_clash = s0_mem && s1_mem;
        solo_kind  = s0_branch || s1_branch || s0_mull || s1_mull;
        waw_hit    = s0_wen && s1_wen && (s0_dst == s1_dst);
        pair_ok    = s1_valid && !port_clash && !solo_kind && !waw_hit &&
                     !raw_hit && !ld_hit1;
    end
endmodule

// File: rtl/dip_load_track.sv
module dip_load_track
    import dip_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          issue0,
    input  logic          issue1,
    input  logic          s0_mem,
    input  logic          s0_wen,
    input  logic [RW-1:0] s0_dst,
    input  logic          s1_mem,
    input  logic          s1_wen,
    input  logic [RW-1:0] s1_dst,
    output logic          pend_q,
    output logic [RW-1:0] dst_q
);
    ld_track_t trk_d, trk_q;
    logic      load0, load1;

    always_comb begin
        load0 = s0_mem && s0_wen;
        load1 = s1_mem && s1_wen;
        trk_d = '0;
        if (!flush) begin
            if (issue1 && load1) begin
                trk_d.pend = 1'b1;
                trk_d.dst  = s1_dst;
            end else if (issue0 && load0) begin
                trk_d.pend = 1'b1;
                trk_d.dst  = s0_dst;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign pend_q = trk_q.pend;
    assign dst_q  = trk_q.dst;

    AST_LOAD_REMEMBERED: assert property (@(posedge clk) disable iff (!rst_n)
        (issue0 && load0 && !issue1 && !flush) |=> (pend_q && dst_q == $past(s0_dst))); // R8
    AST_FLUSH_FORGETS: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pend_q); // R10
endmodule

// File: rtl/dip_issue_ctrl.sv
module dip_issue_ctrl
    import dip_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          s0_valid,
    input  logic          s0_wen,
    input  logic [RW-1:0] s0_dst,
    input  logic          s0_sa_en,
    input  logic [RW-1:0] s0_sa,
    input  logic          s0_sb_en,
    input  logic [RW-1:0] s0_sb,
    input  logic          s0_mem,
    input  logic          s0_branch,
    input  logic          s0_mull,
    input  logic          s1_valid,
    input  logic          s1_wen,
    input  logic [RW-1:0] s1_dst,
    input  logic          s1_sa_en,
    input  logic [RW-1:0] s1_sa,
    input  logic          s1_sb_en,
    input  logic [RW-1:0] s1_sb,
    input  logic          s1_mem,
    input  logic          s1_branch,
    input  logic          s1_mull,
    output logic          issue0,
    output logic          issue1,
    output logic          hold1,
    output logic [CW-1:0] consumed
);
    localparam int NCHK = 3;

    logic          pend_q;
    logic [RW-1:0] ld_dst_q;
    logic          pair_ok;

    // check 0: lead vs pending load, 1: trail vs pending load, 2: trail vs lead dst
    logic          pv   [NCHK];
    logic [RW-1:0] preg [NCHK];
    logic          cae  [NCHK];
    logic [RW-1:0] ca   [NCHK];
    logic          cbe  [NCHK];
    logic [RW-1:0] cb   [NCHK];
    logic [NCHK-1:0] hits;

    always_comb begin
        pv[0] = pend_q;   preg[0] = ld_dst_q;
        cae[0] = s0_sa_en; ca[0] = s0_sa; cbe[0] = s0_sb_en; cb[0] = s0_sb;
        pv[1] = pend_q;   preg[1] = ld_dst_q;
        cae[1] = s1_sa_en; ca[1] = s1_sa; cbe[1] = s1_sb_en; cb[1] = s1_sb;
        pv[2] = s0_wen;   preg[2] = s0_dst;
        cae[2] = s1_sa_en; ca[2] = s1_sa; cbe[2] = s1_sb_en; cb[2] = s1_sb;
    end

    for (genvar g = 0; g < NCHK; g++) begin : g_chk
        dip_reads u_rd (
            .probe_valid (pv[g]),
            .probe_reg   (preg[g]),
            .sa_en       (cae[g]),
            .sa          (ca[g]),
            .sb_en       (cbe[g]),
            .sb          (cb[g]),
            .hit         (hits[g])
        );
    end

    dip_pair_rules u_rules (
        .s1_valid  (s1_valid),
        .s0_wen    (s0_wen),
        .s0_dst    (s0_dst),
        .s1_wen    (s1_wen),
        .s1_dst    (s1_dst),
        .s0_mem    (s0_mem),
        .s1_mem    (s1_mem),
        .s0_branch (s0_branch),
        .s1_branch (s1_branch),
        .s0_mull   (s0_mull),
        .s1_mull   (s1_mull),
        .raw_hit   (hits[2]),
        .ld_hit1   (hits[1]),
        .pair_ok   (pair_ok)
    );

    always_comb begin
        issue0   = s0_valid && !flush && !hits[0];
        issue1   = issue0 && pair_ok;
        hold1    = s1_valid && !issue1;
        consumed = CW'(issue0) + CW'(issue1);
    end

    dip_load_track u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush  (flush),
        .issue0 (issue0),
        .issue1 (issue1),
        .s0_mem (s0_mem),
        .s0_wen (s0_wen),
        .s0_dst (s0_dst),
        .s1_mem (s1_mem),
        .s1_wen (s1_wen),
        .s1_dst (s1_dst),
        .pend_q (pend_q),
        .dst_q  (ld_dst_q)
    );

    AST_ONE_MEM_PORT: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> !(s0_mem && s1_mem)); // R2
    AST_NO_RAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (issue1 && s0_wen) |-> !((s1_sa_en && s1_sa == s0_dst) || (s1_sb_en && s1_sb == s0_dst))); // R3
    AST_NO_WAW_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> !(s0_wen && s1_wen && s0_dst == s1_dst)); // R4
    AST_BRANCH_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> !(s0_branch || s1_branch)); // R5
    AST_MULL_SOLO: assert property (@(posedge clk) disable iff (!rst_n)
        issue1 |-> !(s0_mull || s1_mull)); // R6
    AST_COUNT_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (consumed == (CW'(issue0) + CW'(issue1))) && (issue1 -> issue0)); // R7
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> (!issue0 && !issue1)); // R10
    AST_NO_LEAD_NO_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
        !s0_valid |-> (!issue0 && !issue1)); // R11
endmodule

// File: tb/dip_issue_ctrl_test.sv
module dip_issue_ctrl_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic s0_valid, s0_wen, s0_sa_en, s0_sb_en, s0_mem, s0_branch, s0_mull;
    logic [3:0] s0_dst, s0_sa, s0_sb;
    logic s1_valid, s1_wen, s1_sa_en, s1_sb_en, s1_mem, s1_branch, s1_mull;
    logic [3:0] s1_dst, s1_sa, s1_sb;
    logic issue0, issue1, hold1;
    logic [1:0] consumed;
    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    dip_issue_ctrl uut (.*);

    task automatic lead(input logic v, input logic w, input logic [3:0] d,
                        input logic ae, input logic [3:0] a, input logic be, input logic [3:0] b,
                        input logic m, input logic br, input logic ml);
        s0_valid = v; s0_wen = w; s0_dst = d; s0_sa_en = ae; s0_sa = a;
        s0_sb_en = be; s0_sb = b; s0_mem = m; s0_branch = br; s0_mull = ml;
    endtask

    task automatic trail(input logic v, input logic w, input logic [3:0] d,
                         input logic ae, input logic [3:0] a, input logic be, input logic [3:0] b,
                         input logic m, input logic br, input logic ml);
        s1_valid = v; s1_wen = w; s1_dst = d; s1_sa_en = ae; s1_sa = a;
        s1_sb_en = be; s1_sb = b; s1_mem = m; s1_branch = br; s1_mull = ml;
    endtask

    task automatic idle();
        @(negedge clk);
        flush = 1'b0;
        lead (0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        @(negedge clk);
    endtask

    task automatic expect_out(input string req, input logic e0, input logic e1,
                              input logic eh, input logic [1:0] ec);
        #2;
        n_chk++;
        if ({issue0, issue1, hold1, consumed} !== {e0, e1, eh, ec}) begin
            n_bad++;
            $display("FAIL %s: got i0=%b i1=%b h=%b n=%0d exp i0=%b i1=%b h=%b n=%0d",
                     req, issue0, issue1, hold1, consumed, e0, e1, eh, ec);
        end
    endtask

    // independent ALU op writing d and reading a, b
    task automatic alu_lead(input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
        lead(1,1,d,1,a,1,b,0,0,0);
    endtask
    task automatic alu_trail(input logic [3:0] d, input logic [3:0] a, input logic [3:0] b);
        trail(1,1,d,1,a,1,b,0,0,0);
    endtask

    task automatic t_reset();
        lead (0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R1 during reset", 0,0,0,2'd0);
        @(negedge clk); rst_n = 1'b1;
        expect_out("R1 after reset", 0,0,0,2'd0);
        alu_lead(4'd3, 4'd5, 4'd0);
        expect_out("R1 no stale load", 1,0,0,2'd1);
        idle();
    endtask

    task automatic t_pairs();
        @(negedge clk);
        alu_lead(4'd1, 4'd2, 4'd3); alu_trail(4'd4, 4'd5, 4'd6);
        expect_out("R7 independent pair", 1,1,0,2'd2);
        @(negedge clk);
        lead(1,0,4'd0,1,4'd2,1,4'd3,1,0,0); trail(1,1,4'd7,1,4'd8,0,4'd0,1,0,0);
        expect_out("R2 two memory ops", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd9, 4'd2, 4'd3); alu_trail(4'd4, 4'd1, 4'd9);
        expect_out("R3 raw on second source", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd6, 4'd2, 4'd3); alu_trail(4'd6, 4'd1, 4'd5);
        expect_out("R4 same destination", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd1, 4'd2, 4'd3); trail(1,0,4'd0,1,4'd7,1,4'd8,0,1,0);
        expect_out("R5 branch in trail slot", 1,0,1,2'd1);
        @(negedge clk);
        lead(1,0,4'd0,1,4'd7,0,4'd0,0,1,0); alu_trail(4'd4, 4'd5, 4'd6);
        expect_out("R5 branch in lead slot", 1,0,1,2'd1);
        @(negedge clk);
        lead(1,1,4'd1,1,4'd2,1,4'd3,0,0,1); alu_trail(4'd4, 4'd5, 4'd6);
        expect_out("R6 long multiply lead", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd1, 4'd2, 4'd3); trail(1,1,4'd4,1,4'd5,1,4'd6,0,0,1);
        expect_out("R6 long multiply trail", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd0, 4'd2, 4'd3); alu_trail(4'd4, 4'd0, 4'd5);
        expect_out("R12 raw through register 0", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd0, 4'd2, 4'd3); alu_trail(4'd0, 4'd5, 4'd6);
        expect_out("R12 waw on register 0", 1,0,1,2'd1);
        @(negedge clk);
        alu_lead(4'd9, 4'd2, 4'd3); trail(1,1,4'd4,0,4'd9,0,4'd9,0,0,0);
        expect_out("R13 disabled sources", 1,1,0,2'd2);
        @(negedge clk);
        alu_lead(4'd1, 4'd2, 4'd3); trail(0,1,4'd1,1,4'd1,0,4'd0,1,1,1);
        expect_out("R11 trail invalid", 1,0,0,2'd1);
        @(negedge clk);
        lead(0,1,4'd1,1,4'd2,0,4'd0,0,0,0); alu_trail(4'd4, 4'd5, 4'd6);
        expect_out("R11 lead invalid", 0,0,1,2'd0);
        idle();
    endtask

    task automatic t_load_use();
        @(negedge clk);
        lead(1,1,4'd5,1,4'd2,0,4'd0,1,0,0); trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R8 load issues", 1,0,0,2'd1);
        @(negedge clk);
        alu_lead(4'd8, 4'd5, 4'd1); alu_trail(4'd9, 4'd2, 4'd3);
        expect_out("R8 stall cycle", 0,0,1,2'd0);
        @(negedge clk);
        expect_out("R8 resumes after one cycle", 1,1,0,2'd2);
        idle();
        // load carried in the trail slot, then a disabled-source reader
        @(negedge clk);
        alu_lead(4'd1, 4'd2, 4'd3); trail(1,1,4'd7,1,4'd4,0,4'd0,1,0,0);
        expect_out("R8 load in trail slot", 1,1,0,2'd2);
        @(negedge clk);
        lead(1,1,4'd8,0,4'd7,0,4'd7,0,0,0); trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R13 disabled source no stall", 1,0,0,2'd1);
        idle();
    endtask

    task automatic t_trail_load_use();
        @(negedge clk);
        lead(1,1,4'd7,1,4'd2,0,4'd0,1,0,0); trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R9 load issues", 1,0,0,2'd1);
        @(negedge clk);
        alu_lead(4'd3, 4'd1, 4'd2); alu_trail(4'd4, 4'd7, 4'd6);
        expect_out("R9 trail needs load", 1,0,1,2'd1);
        idle();
    endtask

    task automatic t_flush();
        @(negedge clk);
        lead(1,1,4'd6,1,4'd2,0,4'd0,1,0,0); trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R10 load before flush", 1,0,0,2'd1);
        @(negedge clk);
        flush = 1'b1;
        alu_lead(4'd1, 4'd2, 4'd3); alu_trail(4'd4, 4'd5, 4'd9);
        expect_out("R10 flush cancels", 0,0,1,2'd0);
        @(negedge clk);
        flush = 1'b0;
        alu_lead(4'd1, 4'd6, 4'd3); trail(0,0,4'd0,0,4'd0,0,4'd0,0,0,0);
        expect_out("R10 load forgotten", 1,0,0,2'd1);
        idle();
    endtask

    initial begin
        #4000000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        t_reset();
        t_pairs();
        t_load_use();
        t_trail_load_use();
        t_flush();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule